// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides a free-running clock by an exact rational ratio. A prescaler counter ends each output cycle after either `N` or `N+1` input clocks. A frame controller decides which length each cycle gets. Over every frame of `A+B` output cycles, exactly `A` cycles are short (`N` clocks) and `B` cycles are long (`N+1` clocks). One frame therefore spans `A*N + B*(N+1)` input clocks and produces `A+B` output pulses, so the output rate is Fin·(A+B)/(A·N + B·(N+1)).

A build-time parameter sets how the short and long cycles are ordered inside a frame:

- **Grouped ordering** places every short cycle first and every long cycle after them. It needs only a frame counter, but the phase error grows across the frame.
- **Spread ordering** uses a modulo error accumulator to scatter the long cycles as evenly as possible. This keeps the timing error within about one input clock.

The block has two outputs. The first is a one-clock pulse at the end of every output cycle. The second is a registered copy of the modulus choice for the cycle that just ended.

Top module: `dual_mod_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `pulseOut` and `modCtrlOut` are 0 after that edge.
- R2: `pulseOut` is never high on two consecutive cycles. Once running, the distance between two pulses is always `N` or `N+1` input clocks.
- R3: Every frame of `A+B` consecutive output cycles, counted from reset, holds exactly `B` long cycles. It therefore spans `A*N + B*(N+1)` input clocks.
- R4: With `INTERLEAVE = 0`, cycle `k` of a frame (k = 0 .. A+B-1) is short when `k < A` and long otherwise.
- R5: With `INTERLEAVE = 1`, cycle `k` of a frame is long exactly when floor((k+1)·B/(A+B)) > floor(k·B/(A+B)).
- R6: In the cycle where `pulseOut` is high, `modCtrlOut` shows the cycle that just ended: 1 if it lasted `N+1` clocks, 0 if it lasted `N`. It holds that value until the next pulse.
- R7: With `B = 0`, the block is a plain divide-by-`N`, with a pulse every `N` clocks.
- R8: Reset, whenever applied, restarts the frame at cycle 0. After release, the first pulse follows after `N` clocks (or `N+1` if cycle 0 is long).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| pulseOut | output | 1 | One-clock pulse at the end of each output cycle |
| modCtrlOut | output | 1 | Modulus of the cycle just ended (1 = long), updated with each pulse |

## Verification
The checker watches several properties on every clock:

- the prescaler count never leaves 0..N;
- pulses are single-clock;
- the gap between pulses is N or N+1;
- the modulus output moves only with a pulse;
- every frame contains exactly B long cycles.

These properties cannot tell grouped from spread ordering, or detect a misplaced long cycle inside a frame. The bench scenarios cover those by comparing each measured interval with the ordering formula for its mode. They also cover the first cycle after reset and a restart in the middle of a frame.

// File: rtl/dmdiv_pkg.sv
package dmdiv_pkg;

  // Strobe from the frame controller to the prescaler datapath.
  typedef struct packed {
    logic useLong;   // current output cycle lasts N+1 clocks
  } modSel_t;

  // Strobe from the prescaler datapath back to the controller.
  typedef struct packed {
    logic cycleEnd;  // last input clock of the current output cycle
  } psStat_t;

endpackage

// File: rtl/dmdiv_prescaler.sv
module dmdiv_prescaler
  import dmdiv_pkg::*;
#(
  parameter int N = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  modSel_t                 sel,
  output psStat_t                 stat,
  output logic                    pulseOut,
  output logic                    modOut,
  output logic [$clog2(N+1)-1:0]  count
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(N - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(N);

  logic [CW-1:0] cnt;
  logic          atEnd;

  // The terminal value depends on the modulus chosen for this cycle.
  always_comb begin
    atEnd = (cnt == (sel.useLong ? LONG_LAST : SHORT_LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      pulseOut <= 1'b0;
      modOut   <= 1'b0;
    end else begin
      cnt      <= atEnd ? '0 : cnt + 1'b1;
      pulseOut <= atEnd;
      if (atEnd) begin
        modOut <= sel.useLong;
      end
    end
  end

  assign stat.cycleEnd = atEnd;
  assign count         = cnt;

endmodule

// File: rtl/dmdiv_controller.sv
module dmdiv_controller
  import dmdiv_pkg::*;
#(
  parameter int A          = 2,
  parameter int B          = 3,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  psStat_t stat,
  output modSel_t sel
);

  localparam int   FRAME      = A + B;
  localparam logic FIRST_LONG = (A == 0);

  logic longReg;

  generate
    if (INTERLEAVE) begin : g_spread
      // Error accumulator: add B modulo FRAME per output cycle.
      // A cycle is long when its addition wraps.
      localparam int SW = $clog2(2 * FRAME + 1);
      localparam logic [SW-1:0] B_W = SW'(B);
      localparam logic [SW-1:0] F_W = SW'(FRAME);

      logic [SW-1:0] acc;
      logic [SW-1:0] sumNow;
      logic [SW-1:0] accNext;
      logic [SW-1:0] sumNext;

      always_comb begin
        sumNow  = acc + B_W;
        accNext = (sumNow >= F_W) ? sumNow - F_W : sumNow;
        sumNext = accNext + B_W;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          acc     <= '0;
          longReg <= FIRST_LONG;
        end else if (stat.cycleEnd) begin
          acc     <= accNext;
          longReg <= (sumNext >= F_W);
        end
      end
    end else begin : g_group
      // Frame counter: the first A cycles are short, the rest are long.
      localparam int FW = (FRAME > 1) ? $clog2(FRAME) : 1;
      localparam logic [FW-1:0] LAST_IDX = FW'(FRAME - 1);
      localparam logic [FW:0]   A_W      = (FW + 1)'(A);

      logic [FW-1:0] idx;
      logic [FW-1:0] idxNext;

      always_comb begin
        idxNext = (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          idx     <= '0;
          longReg <= FIRST_LONG;
        end else if (stat.cycleEnd) begin
          idx     <= idxNext;
          longReg <= ({1'b0, idxNext} >= A_W);
        end
      end
    end
  endgenerate

  assign sel.useLong = longReg;

endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider
  import dmdiv_pkg::*;
#(
  parameter int N          = 3,
  parameter int A          = 2,
  parameter int B          = 3,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output logic pulseOut,
  output logic modCtrlOut
);

  localparam int CW = $clog2(N + 1);

  modSel_t       selW;
  psStat_t       statW;
  logic [CW-1:0] psCount;

  dmdiv_controller #(
    .A(A), .B(B), .INTERLEAVE(INTERLEAVE)
  ) ctrl_i (
    .clk  (clk),
    .rst  (rst),
    .stat (statW),
    .sel  (selW)
  );

  dmdiv_prescaler #(
    .N(N)
  ) ps_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (selW),
    .stat     (statW),
    .pulseOut (pulseOut),
    .modOut   (modCtrlOut),
    .count    (psCount)
  );

endmodule

// File: rtl/dual_mod_divider_chk.sv
module dual_mod_divider_chk #(
  parameter int N = 3,
  parameter int A = 2,
  parameter int B = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pulseOut,
  input logic                   modCtrlOut,
  input logic [$clog2(N+1)-1:0] psCount
);

  localparam int CW    = $clog2(N + 1);
  localparam int FRAME = A + B;
  localparam int GW    = $clog2(N + 3);
  localparam int FW    = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(N + 2);

  logic [GW-1:0] gapCnt;
  logic          seenPulse;
  logic [FW-1:0] pulseIdx;
  logic [FW:0]   longCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt    <= '0;
      seenPulse <= 1'b0;
      pulseIdx  <= '0;
      longCnt   <= '0;
    end else begin
      if (pulseOut) begin
        gapCnt    <= GW'(1);
        seenPulse <= 1'b1;
        if (pulseIdx == FW'(FRAME - 1)) begin
          pulseIdx <= '0;
          longCnt  <= '0;
        end else begin
          pulseIdx <= pulseIdx + 1'b1;
          longCnt  <= longCnt + (FW + 1)'(modCtrlOut);
        end
      end else if (gapCnt != GAP_MAX) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulseOut |=> !pulseOut);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    psCount <= CW'(N));

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pulseOut && seenPulse) |-> (gapCnt == GW'(N) || gapCnt == GW'(N + 1)));

  // R6
  mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pulseOut |-> $stable(modCtrlOut));

  // R3
  frame_long_chk: assert property (@(posedge clk) disable iff (rst)
    (pulseOut && pulseIdx == FW'(FRAME - 1))
      |-> ((longCnt + (FW + 1)'(modCtrlOut)) == (FW + 1)'(B)));

endmodule

bind dual_mod_divider dual_mod_divider_chk #(
  .N(N), .A(A), .B(B)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pulseOut   (pulseOut),
  .modCtrlOut (modCtrlOut),
  .psCount    (psCount)
);

// File: tb/dual_mod_divider_tb_top.sv
`timescale 1ns/1ps
module dual_mod_divider_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;

  logic [3:0] pulseV;
  logic [3:0] modV;

  always #2.5 clk = ~clk;

  // 0: spread  N=3 A=2 B=3
  dual_mod_divider #(.N(3), .A(2), .B(3), .INTERLEAVE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .pulseOut(pulseV[0]), .modCtrlOut(modV[0]));
  // 1: grouped N=3 A=2 B=3
  dual_mod_divider #(.N(3), .A(2), .B(3), .INTERLEAVE(1'b0)) dutGroup_i (
    .clk(clk), .rst(rst), .pulseOut(pulseV[1]), .modCtrlOut(modV[1]));
  // 2: plain N=4 A=3 B=0
  dual_mod_divider #(.N(4), .A(3), .B(0), .INTERLEAVE(1'b1)) dutPlain_i (
    .clk(clk), .rst(rst), .pulseOut(pulseV[2]), .modCtrlOut(modV[2]));
  // 3: all long N=2 A=0 B=2
  dual_mod_divider #(.N(2), .A(0), .B(2), .INTERLEAVE(1'b0)) dutLong_i (
    .clk(clk), .rst(rst), .pulseOut(pulseV[3]), .modCtrlOut(modV[3]));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit expLong(input int k, input int a, input int b,
                                 input bit spread);
    int f = a + b;
    int j = k % f;
    if (spread) return ((j + 1) * b) / f > (j * b) / f;
    return j >= a;
  endfunction

  task automatic applyReset(input string req);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(pulseV[i] == 1'b0, req, $sformatf("pulse in reset dut %0d", i), pulseV[i], 0);
      check(modV[i] == 1'b0, req, $sformatf("mod in reset dut %0d", i), modV[i], 0);
    end
    rst = 1'b0;
  endtask

  // Watches one instance from reset release for a number of output cycles.
  task automatic runCycles(input int idx, input int n, input int a, input int b,
                           input bit spread, input int cycles, input string tag);
    int  edges = 0;
    int  last = 0;
    int  k = 0;
    int  frameSum = 0;
    bit  prevPulse = 1'b0;
    bit  expMod = 1'b0;
    int  f = a + b;
    while (k < cycles) begin
      @(negedge clk);
      edges++;
      if (pulseV[idx]) begin
        bit lg = expLong(k, a, b, spread);
        int expLen = n + int'(lg);
        check(!prevPulse, "R2", "pulse wider than one clock", 1, 0);
        check(edges - last == expLen, tag,
              $sformatf("length of cycle %0d", k), edges - last, expLen);
        check(modV[idx] == lg, "R6", $sformatf("modulus of cycle %0d", k),
              modV[idx], int'(lg));
        frameSum += edges - last;
        if ((k % f) == f - 1) begin
          check(frameSum == a * n + b * (n + 1), "R3", "frame length",
                frameSum, a * n + b * (n + 1));
          frameSum = 0;
        end
        expMod = lg;
        last = edges;
        k++;
        prevPulse = 1'b1;
      end else begin
        if (modV[idx] != expMod)
          check(1'b0, "R6", "modulus changed between pulses", modV[idx], int'(expMod));
        prevPulse = 1'b0;
      end
    end
  endtask

  task automatic testSpread;
    applyReset("R1");
    runCycles(0, 3, 2, 3, 1'b1, 15, "R5");
  endtask

  task automatic testGrouped;
    applyReset("R1");
    runCycles(1, 3, 2, 3, 1'b0, 15, "R4");
  endtask

  task automatic testPlain;
    applyReset("R1");
    runCycles(2, 4, 3, 0, 1'b1, 9, "R7");
  endtask

  task automatic testAllLong;
    applyReset("R1");
    runCycles(3, 2, 0, 2, 1'b0, 6, "R4");
  endtask

  task automatic testMidReset;
    applyReset("R1");
    runCycles(0, 3, 2, 3, 1'b1, 7, "R5");
    applyReset("R8");
    runCycles(0, 3, 2, 3, 1'b1, 10, "R8");
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    testSpread();
    testGrouped();
    testPlain();
    testAllLong();
    testMidReset();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule